// File: doc/BRIEF.md
# Real-Time Interval Counter

This block keeps elapsed time as four cascaded byte fields: a 1/128-second count, seconds, minutes and hours. One cycle-wide strobe at 128 Hz drives it. When the clock-enable bit is set, each strobe advances the 1/128-second field. A field that wraps carries into the next field on the same strobe. The hour field wraps after 23 in 24-hour mode and after 255 otherwise.

An interval timer sits beside the time fields. It counts events of one chosen timebase: strobes, seconds carries, minutes carries or hours carries. When its count equals the programmed interval, it raises an interrupt flag. After that it either reloads and keeps timing, or stops until software disables it and enables it again.

Software reaches six byte registers through a simple write port and a combinational read port.

The interval timer is a three-state machine:
- `S_IDLE`: disabled, count held at zero.
- `S_RUN`: counting events of the chosen timebase.
- `S_HOLD`: a single-shot match has happened and the count is frozen.

Its transitions are:
- `IDLE→RUN` when the enable bit is 1.
- `RUN→RUN` on a match in reload mode, with the count returning to 0.
- `RUN→HOLD` on a match in single-shot mode.
- `RUN→IDLE` and `HOLD→IDLE` when the enable bit is 0.

Top module: `rtc_interval_counter`

## Requirements
- R1: After reset, every register reads 0, `irq` is 0 and the interval timer is idle.
- R2: The registers are at these addresses: 0 control, 1 interval, 2 the 1/128-second field, 3 seconds, 4 minutes, 5 hours. The control bits are:
  - bit0: clock enable.
  - bit1: interval enable.
  - bit2: interrupt flag.
  - bit3: single-shot mode.
  - bits5:4: timebase.
  - bit6: 24-hour mode.
  - bit7: always reads 0.

  A written value reads back on the next cycle.
- R3: The 1/128-second field counts from 0 to 127, and seconds and minutes count from 0 to 59. A wrap carries into the next field on the same strobe.
- R4: With control bit6 = 1, hours wrap from 23 to 0. With bit6 = 0, hours count up to 255 and then wrap to 0.
- R5: While control bit0 is 0, the strobe advances no time field and no interval count.
- R6: The timebase field (bits5:4) selects the event the interval timer counts: 0 = strobe, 1 = seconds carry, 2 = minutes carry, 3 = hours carry.
- R7: When the count of selected events reaches the interval register value, the flag (bit2) is set and `irq` goes high on the next cycle.
- R8: With bit3 = 0, the count restarts from 0 at each match, so the flag recurs every interval.
- R9: With bit3 = 1, the timer stops after the first match and raises no further match.
- R10: Writing bit1 = 0 stops the interval timer and clears its count. Timing after it is enabled again starts from zero.
- R11: Writing 0 to bit2 clears the flag. Writing 1 to bit2 does not set it.
- R12: A write to a time field takes effect at once, and counting continues from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_128 | input | 1 | One-cycle strobe at 128 Hz |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| irq | output | 1 | Interval interrupt (the flag) |

## Verification
The time chain is driven from a table of preset values and strobe counts. The presets place the chain at:
- no carry;
- a single 1/128-second wrap;
- a two-level carry;
- a full carry into hours in both hour modes;
- the 255-hour wrap;
- a span longer than one second.

Each preset isolates one limit comparison.

Directed runs then exercise the interval timer in each timebase. Presets put the triggering carry one strobe away, so a timer on the wrong timebase shows up as a missing or early interrupt. The same runs contrast reload mode with single-shot mode, a disable in mid-count, and writes of 0 and 1 to the flag.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int DW = 8;
    localparam int AW = 3;

    localparam logic [AW-1:0] A_CTRL = 3'd0;
    localparam logic [AW-1:0] A_IVAL = 3'd1;
    localparam logic [AW-1:0] A_FRAC = 3'd2;
    localparam logic [AW-1:0] A_SEC  = 3'd3;
    localparam logic [AW-1:0] A_MIN  = 3'd4;
    localparam logic [AW-1:0] A_HOUR = 3'd5;

    typedef struct packed {
        logic       rsv;
        logic       h24;
        logic [1:0] tbase;
        logic       single;
        logic       flag;
        logic       ien;
        logic       clk_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_HOLD = 2'd2
    } ivl_state_t;
endpackage

// File: rtl/rtc_wrap_field.sv
module rtc_wrap_field #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic [W-1:0] lim,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic [W-1:0] val,
    output logic         carry
);
    assign carry = inc && (val >= lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     val <= '0;
        else if (ld)    val <= ld_val;
        else if (carry) val <= '0;
        else if (inc)   val <= val + 1'b1;
    end

    // R3 / R4: a field at or past its limit returns to zero on the next increment
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !ld && val >= lim) |=> (val == '0));
    // R5: without an increment or a load the field holds
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !ld) |=> $stable(val));
endmodule

// File: rtl/rtc_interval_fsm.sv
module rtc_interval_fsm
    import rtc_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ien,
    input  logic          single,
    input  logic          pulse,
    input  logic [CW-1:0] ival,
    output logic          match
);
    ivl_state_t    state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;
    logic [CW-1:0] cnt_inc;

    assign cnt_inc = cnt + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        match    = 1'b0;
        unique case (state)
            S_IDLE: begin
                cnt_nx = '0;
                if (ien) state_nx = S_RUN;
            end
            S_RUN: begin
                if (!ien) begin
                    state_nx = S_IDLE;
                    cnt_nx   = '0;
                end else if (pulse) begin
                    if (cnt_inc == ival) begin
                        match = 1'b1;
                        if (single) begin
                            state_nx = S_HOLD;
                            cnt_nx   = cnt_inc;
                        end else begin
                            cnt_nx = '0;
                        end
                    end else begin
                        cnt_nx = cnt_inc;
                    end
                end
            end
            S_HOLD: begin
                if (!ien) begin
                    state_nx = S_IDLE;
                    cnt_nx   = '0;
                end
            end
            default: begin
                state_nx = S_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // R10: an idle timer always holds a zero count
    a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> (cnt == '0));
    // R9: a stopped single-shot timer stays stopped while enabled
    a_r9_hold_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD && ien) |=> (state == S_HOLD && $stable(cnt)));
    // R5: with no timebase event the count does not move while running
    a_r5_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RUN && ien && !pulse) |=> $stable(cnt));
endmodule

// File: rtl/rtc_interval_counter.sv
module rtc_interval_counter
    import rtc_pkg::*;
#(
    parameter int FRAC_MAX  = 127,
    parameter int SM_MAX    = 59,
    parameter int H24_MAX   = 23,
    parameter int HFULL_MAX = 255
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_128,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic          irq
);
    localparam int NF = 4;

    ctrl_t          ctrl;
    logic [DW-1:0]  ival;
    logic [DW-1:0]  fval  [NF];
    logic [DW-1:0]  flim  [NF];
    logic [NF:0]    inc;
    logic           adv;
    logic           pulse;
    logic           match;

    assign adv    = tick_128 && ctrl.clk_en;
    assign inc[0] = adv;

    assign flim[0] = DW'(FRAC_MAX);
    assign flim[1] = DW'(SM_MAX);
    assign flim[2] = DW'(SM_MAX);
    assign flim[3] = ctrl.h24 ? DW'(H24_MAX) : DW'(HFULL_MAX);

    for (genvar i = 0; i < NF; i++) begin : g_field
        logic ld_i;
        assign ld_i = wr_en && (wr_addr == A_FRAC + AW'(i));
        rtc_wrap_field #(.W(DW)) u_field (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (inc[i]),
            .lim    (flim[i]),
            .ld     (ld_i),
            .ld_val (wr_data),
            .val    (fval[i]),
            .carry  (inc[i+1])
        );
    end

    assign pulse = inc[ctrl.tbase];

    rtc_interval_fsm #(.CW(DW)) u_ivl (
        .clk    (clk),
        .rst_n  (rst_n),
        .ien    (ctrl.ien),
        .single (ctrl.single),
        .pulse  (pulse),
        .ival   (ival),
        .match  (match)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= '0;
            ival <= '0;
        end else begin
            if (wr_en && wr_addr == A_CTRL) begin
                ctrl.rsv    <= 1'b0;
                ctrl.h24    <= wr_data[6];
                ctrl.tbase  <= wr_data[5:4];
                ctrl.single <= wr_data[3];
                ctrl.flag   <= (wr_data[2] && ctrl.flag) || match;
                ctrl.ien    <= wr_data[1];
                ctrl.clk_en <= wr_data[0];
            end else if (match) begin
                ctrl.flag <= 1'b1;
            end
            if (wr_en && wr_addr == A_IVAL) ival <= wr_data;
        end
    end

    always_comb begin
        unique case (rd_addr)
            A_CTRL:  rd_data = ctrl;
            A_IVAL:  rd_data = ival;
            A_FRAC:  rd_data = fval[0];
            A_SEC:   rd_data = fval[1];
            A_MIN:   rd_data = fval[2];
            A_HOUR:  rd_data = fval[3];
            default: rd_data = '0;
        endcase
    end

    assign irq = ctrl.flag;

    // R7: the flag rises only after a match in the previous cycle
    a_r7_flag_src: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(match));
    // R11: the flag never rises from a software write alone
    a_r11_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !match) |=> !irq);
    // R5: clock enable low freezes the 1/128-second field
    a_r5_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.clk_en && !(wr_en && wr_addr == A_FRAC)) |=> $stable(fval[0]));
endmodule

// File: tb/tb_rtc_interval_counter.sv
module tb_rtc_interval_counter;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_128 = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq;

    int n_run = 0;
    int n_fail = 0;

    rtc_interval_counter dut (
        .clk(clk), .rst_n(rst_n), .tick_128(tick_128),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic [7:0]  p_frac, p_sec, p_min, p_hour;
        logic        h24;
        logic [15:0] nticks;
        logic [7:0]  e_frac, e_sec, e_min, e_hour;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{8'd0,   8'd0,  8'd0,  8'd0,   1'b0, 16'd5,   8'd5, 8'd0,  8'd0, 8'd0},
        '{8'd127, 8'd0,  8'd0,  8'd0,   1'b0, 16'd1,   8'd0, 8'd1,  8'd0, 8'd0},
        '{8'd127, 8'd59, 8'd0,  8'd0,   1'b0, 16'd1,   8'd0, 8'd0,  8'd1, 8'd0},
        '{8'd127, 8'd59, 8'd59, 8'd23,  1'b1, 16'd1,   8'd0, 8'd0,  8'd0, 8'd0},
        '{8'd127, 8'd59, 8'd59, 8'd23,  1'b0, 16'd1,   8'd0, 8'd0,  8'd0, 8'd24},
        '{8'd127, 8'd59, 8'd59, 8'd255, 1'b0, 16'd1,   8'd0, 8'd0,  8'd0, 8'd0},
        '{8'd100, 8'd10, 8'd5,  8'd3,   1'b1, 16'd30,  8'd2, 8'd11, 8'd5, 8'd3},
        '{8'd127, 8'd58, 8'd59, 8'd5,   1'b1, 16'd129, 8'd0, 8'd0,  8'd0, 8'd6}
    };

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_128 = 1'b1;
            @(negedge clk); tick_128 = 1'b0;
        end
    endtask

    task automatic preset(input logic [7:0] f, s, m, h);
        wr(3'd2, f); wr(3'd3, s); wr(3'd4, m); wr(3'd5, h);
    endtask

    initial begin
        #1500000;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), d); chk("R1 reset reg", d, 8'd0);
        end
        chk("R1 irq", {7'd0, irq}, 8'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: readback of control and interval
        wr(3'd0, 8'hF9); rd(3'd0, d); chk("R2 ctrl readback", d, 8'h79);
        wr(3'd1, 8'hA5); rd(3'd1, d); chk("R2 ival readback", d, 8'hA5);
        wr(3'd3, 8'd30); rd(3'd3, d); chk("R12 sec write", d, 8'd30);

        // R3/R4/R12: table of presets and strobe counts
        for (int v = 0; v < NV; v++) begin
            wr(3'd0, {1'b0, VEC[v].h24, 6'b000001});
            preset(VEC[v].p_frac, VEC[v].p_sec, VEC[v].p_min, VEC[v].p_hour);
            ticks(int'(VEC[v].nticks));
            rd(3'd2, d); chk("R3 frac", d, VEC[v].e_frac);
            rd(3'd3, d); chk("R3 sec",  d, VEC[v].e_sec);
            rd(3'd4, d); chk("R3 min",  d, VEC[v].e_min);
            rd(3'd5, d); chk("R4 hour", d, VEC[v].e_hour);
        end

        // R5: clock enable off
        wr(3'd0, 8'h00);
        preset(8'd10, 8'd0, 8'd0, 8'd0);
        ticks(5);
        rd(3'd2, d); chk("R5 frozen frac", d, 8'd10);

        // R7/R8: strobe timebase, reload mode
        preset(8'd0, 8'd0, 8'd0, 8'd0);
        wr(3'd1, 8'd3);
        wr(3'd0, 8'h03);
        ticks(2); chk("R7 no early irq", {7'd0, irq}, 8'd0);
        ticks(1); chk("R7 irq at match", {7'd0, irq}, 8'd1);
        rd(3'd0, d); chk("R7 flag bit2", {7'd0, d[2]}, 8'd1);
        wr(3'd0, 8'h03); chk("R11 clear by 0", {7'd0, irq}, 8'd0);
        ticks(2); chk("R8 no early reload irq", {7'd0, irq}, 8'd0);
        ticks(1); chk("R8 reload irq", {7'd0, irq}, 8'd1);

        // R11: writing 1 to the flag does not set it
        wr(3'd0, 8'h01);
        wr(3'd0, 8'h05);
        rd(3'd0, d); chk("R11 write 1 ignored", {7'd0, d[2]}, 8'd0);
        chk("R11 irq stays low", {7'd0, irq}, 8'd0);

        // R9: single-shot
        wr(3'd1, 8'd2);
        wr(3'd0, 8'h0B);
        ticks(2); chk("R9 first match", {7'd0, irq}, 8'd1);
        wr(3'd0, 8'h0B);
        ticks(5); chk("R9 no second match", {7'd0, irq}, 8'd0);

        // R10: disable clears the count
        wr(3'd0, 8'h01);
        wr(3'd1, 8'd4);
        wr(3'd0, 8'h03);
        ticks(2);
        wr(3'd0, 8'h01);
        @(negedge clk);
        wr(3'd0, 8'h03);
        ticks(2); chk("R10 count restarted", {7'd0, irq}, 8'd0);
        ticks(2); chk("R10 match after restart", {7'd0, irq}, 8'd1);

        // R6: seconds timebase
        wr(3'd0, 8'h01);
        preset(8'd120, 8'd0, 8'd0, 8'd0);
        wr(3'd1, 8'd2);
        wr(3'd0, 8'h13);
        ticks(8); chk("R6 one second carry only", {7'd0, irq}, 8'd0);
        ticks(128); chk("R6 seconds match", {7'd0, irq}, 8'd1);

        // R6: minutes timebase
        wr(3'd0, 8'h01);
        preset(8'd127, 8'd58, 8'd0, 8'd0);
        wr(3'd1, 8'd1);
        wr(3'd0, 8'h23);
        ticks(1); chk("R6 minutes no match on sec carry", {7'd0, irq}, 8'd0);
        preset(8'd127, 8'd59, 8'd0, 8'd0);
        ticks(1); chk("R6 minutes match", {7'd0, irq}, 8'd1);

        // R6: hours timebase
        wr(3'd0, 8'h01);
        preset(8'd127, 8'd59, 8'd58, 8'd0);
        wr(3'd0, 8'h33);
        ticks(1); chk("R6 hours no match on min carry", {7'd0, irq}, 8'd0);
        preset(8'd127, 8'd59, 8'd59, 8'd0);
        ticks(1); chk("R6 hours match", {7'd0, irq}, 8'd1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule